// File: doc/BRIEF.md
# Twelve-Bit Variable-Length Instruction Decoder

This block turns a stream of 12-bit instruction words into decoded records. Words arrive on a valid/ready input. Each completed instruction leaves as one registered record on a valid/ready output. The record holds:

- an operation code
- a register selector
- an optional memory-field selector with its enable
- indirect and negative-displacement flags
- a 12-bit value (an address, a displacement magnitude or a literal)
- a length flag and an undefined-encoding flag

Most first words are complete on their own. A first word in the two-word region makes the block keep that word and wait for a second one. The second word carries a 12-bit absolute address or an I/O sub-code. Only after the second word arrives does the block release one merged record. Peripheral one-word I/O, register-operate and flag/skip words are only recognised as groups, with their low bits passed through.

Top module: `w12_decoder`

## Requirements
- R1: A first word whose bits 11:6 are all zero is complete in one word: op 0, value 0, every other field zero. This rule wins over every other group.
- R2: Any other first word with bits 11:9 equal to zero (octal 0100 to 0777) takes a second word. The record then has out_two=1 and out_val equal to the second word.
- R3: For defined two-word memory operations the first word's bits map as follows. Bit 2 drives out_fld_en and bits 1:0 drive out_fld. Bit 4 drives out_ind. Bit 3 sets out_rsel to K (2) when set and to J (1) when clear, but only for ops 1, 4, 5, 6 and 7. All other two-word ops have out_rsel 0.
- R4: Let n be bits 8:5 of the first word. For n from 5 to 13 the op is n-4: 1 skip-not-equal, 2 decrement-skip, 3 increment-skip, 4 subtract, 5 add, 6 load, 7 store, 8 jump, 9 jump-subroutine. Any other two-word first word (below octal 0240, or n of 14 or 15 other than octal 0740) gives op 31 with out_undef=1. In that case only out_two and out_val are nonzero.
- R5: First word octal 0740 gives op 10 when the second word minus octal 0100 names a populated I/O slot. The populated slots are 1, 2, 4, 8, 17, 18, 20, 24, 33, 34, 36, 41, 42 and 44. Otherwise the record is op 31 with out_undef=1. This includes any second word below octal 0100.
- R6: Bits 11:8 equal to 0100 give a one-word literal record. The op is 11 plus bits 7:6 (11 AND-forward, 12 AND-literal, 13 ADD-literal, 14 SUBTRACT-literal), and out_val is bits 5:0.
- R7: Bits 11:8 from 0101 to 1110 give a one-word memory reference. The op is 15 plus (bits 11:8 minus 5). out_val is the magnitude in bits 5:0, out_neg is bit 6 and out_ind is bit 7.
- R8: The remaining one-word groups are decoded as follows. Bits 11:8 = 0010 give op 25 and 0011 give op 26. In both, out_rsel is bits 7:6 (0 special, 1 J, 2 K, 3 JK) and out_val is bits 5:0. Bits 11:8 = 1111 give op 27 with out_val set to bits 7:0.
- R9: While the block waits for a second word and none is offered, out_valid stays low and the held first word is kept.
- R10: While out_valid is high and out_ready is low, every record output holds its value and in_ready is low.
- R11: Synchronous reset clears out_valid and discards a half-received two-word instruction.
- R12: in_ready is high whenever out_valid is low or out_ready is high. A record appears on the clock edge after its last word is accepted, even when the previous record leaves on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_word | input | 12 | Instruction word |
| in_ready | output | 1 | Word will be taken this cycle |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_op | output | 5 | Operation code |
| out_rsel | output | 2 | Register selector: 0 none/special, 1 J, 2 K, 3 JK |
| out_fld_en | output | 1 | Memory-field change requested |
| out_fld | output | 2 | Memory field number |
| out_ind | output | 1 | Indirect address |
| out_neg | output | 1 | Displacement is negative |
| out_val | output | 12 | Address, magnitude or literal |
| out_two | output | 1 | Instruction is two words long |
| out_undef | output | 1 | Undefined encoding |

## Verification
Two things can happen on the same edge: the consumer takes the current record, and the block accepts the word that completes the next instruction. The record must then be replaced rather than dropped or duplicated. The bench provokes this with random gaps on in_valid and random back-pressure on out_ready. It drives a stream that mixes one- and two-word instructions. Each accepted record is compared in order against a model of the requirements, so a lost, repeated or stale record shows up as a mismatch. A directed step also releases a held record while a new word is offered, and expects the new record exactly one cycle later.

// File: rtl/w12_dec_pkg.sv
package w12_dec_pkg;

  localparam int WORD_W    = 12;
  localparam int OP_W      = 5;
  localparam int GRP_W     = 4;

  // operation codes
  localparam logic [OP_W-1:0] OP_STOP      = 5'd0;
  localparam logic [OP_W-1:0] OP_TW_BASE   = 5'd1;
  localparam logic [OP_W-1:0] OP_TWIO      = 5'd10;
  localparam logic [OP_W-1:0] OP_LIT_BASE  = 5'd11;
  localparam logic [OP_W-1:0] OP_MREF_BASE = 5'd15;
  localparam logic [OP_W-1:0] OP_REGOP     = 5'd25;
  localparam logic [OP_W-1:0] OP_FLAGOP    = 5'd26;
  localparam logic [OP_W-1:0] OP_IOGRP     = 5'd27;
  localparam logic [OP_W-1:0] OP_UNDEF     = 5'd31;

  // register selector codes
  localparam logic [1:0] RS_NONE = 2'd0;
  localparam logic [1:0] RS_J    = 2'd1;
  localparam logic [1:0] RS_K    = 2'd2;

  // group codes taken from bits 11:8
  localparam logic [GRP_W-1:0] GRP_REGOP = 4'h2;
  localparam logic [GRP_W-1:0] GRP_FLAG  = 4'h3;
  localparam logic [GRP_W-1:0] GRP_LIT   = 4'h4;
  localparam logic [GRP_W-1:0] GRP_IO    = 4'hF;
  localparam int MREF_FIRST = 5;

  // two-word layout
  localparam int TW_BIAS  = 5;
  localparam int TW_SLOTS = 9;
  localparam logic [WORD_W-1:0] TWIO_WORD = 12'o0740;
  localparam int IO2_BASE  = 64;
  localparam int IO2_SLOTS = 48;
  localparam logic [IO2_SLOTS-1:0] IO2_MASK = 48'h1616_0116_0116;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [1:0]        rsel;
    logic              fld_en;
    logic [1:0]        fld;
    logic              ind;
    logic              neg;
    logic [WORD_W-1:0] val;
    logic              two;
    logic              undef;
  } dec_rec_t;

  function automatic logic is_stop(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:6] == '0;
  endfunction

  function automatic logic is_two_word(input logic [WORD_W-1:0] w);
    return !is_stop(w) && (w[WORD_W-1:9] == '0);
  endfunction

  function automatic logic [3:0] tw_slot(input logic [WORD_W-1:0] w);
    return w[8:5];
  endfunction

  function automatic logic tw_slot_ok(input logic [3:0] s);
    return (s >= 4'(TW_BIAS)) && (s < 4'(TW_BIAS + TW_SLOTS));
  endfunction

  function automatic logic tw_carries_reg(input logic [3:0] idx);
    case (idx)
      4'd0, 4'd3, 4'd4, 4'd5, 4'd6: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic io2_defined(input logic [WORD_W-1:0] s);
    logic [WORD_W-1:0] idx;
    logic [63:0]       m;
    idx = s - 12'(IO2_BASE);
    m   = 64'(IO2_MASK);
    return (s >= 12'(IO2_BASE)) && (idx < 12'(IO2_SLOTS)) && m[idx[5:0]];
  endfunction

endpackage

// File: rtl/w12_first_dec.sv
module w12_first_dec
  import w12_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_rec_t          rec,
  output logic              need_second
);

  logic [GRP_W-1:0] grp;
  assign grp = word[WORD_W-1:WORD_W-GRP_W];

  always_comb begin
    rec         = '0;
    need_second = 1'b0;
    if (is_stop(word)) begin
      rec.op = OP_STOP;
    end else begin
      unique case (grp)
        4'h0, 4'h1: need_second = 1'b1;
        GRP_REGOP, GRP_FLAG: begin
          rec.op   = (grp == GRP_REGOP) ? OP_REGOP : OP_FLAGOP;
          rec.rsel = word[7:6];
          rec.val  = {6'd0, word[5:0]};
        end
        GRP_LIT: begin
          rec.op  = OP_LIT_BASE + {3'd0, word[7:6]};
          rec.val = {6'd0, word[5:0]};
        end
        GRP_IO: begin
          rec.op  = OP_IOGRP;
          rec.val = {4'd0, word[7:0]};
        end
        default: begin
          rec.op  = OP_MREF_BASE + {1'b0, grp - 4'(MREF_FIRST)};
          rec.val = {6'd0, word[5:0]};
          rec.neg = word[6];
          rec.ind = word[7];
        end
      endcase
    end
  end

endmodule

// File: rtl/w12_second_merge.sv
module w12_second_merge
  import w12_dec_pkg::*;
(
  input  logic [WORD_W-1:0] first,
  input  logic [WORD_W-1:0] second,
  output dec_rec_t          rec
);

  logic [3:0] slot;
  logic [3:0] idx;
  assign slot = tw_slot(first);
  assign idx  = slot - 4'(TW_BIAS);

  always_comb begin
    rec     = '0;
    rec.two = 1'b1;
    rec.val = second;
    if (first == TWIO_WORD) begin
      if (io2_defined(second)) begin
        rec.op = OP_TWIO;
      end else begin
        rec.op    = OP_UNDEF;
        rec.undef = 1'b1;
      end
    end else if (tw_slot_ok(slot)) begin
      rec.op     = OP_TW_BASE + {1'b0, idx};
      rec.fld_en = first[2];
      rec.fld    = first[1:0];
      rec.ind    = first[4];
      rec.rsel   = tw_carries_reg(idx) ? (first[3] ? RS_K : RS_J) : RS_NONE;
    end else begin
      rec.op    = OP_UNDEF;
      rec.undef = 1'b1;
    end
  end

endmodule

// File: rtl/w12_decoder.sv
module w12_decoder
  import w12_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OP_W-1:0]   out_op,
  output logic [1:0]        out_rsel,
  output logic              out_fld_en,
  output logic [1:0]        out_fld,
  output logic              out_ind,
  output logic              out_neg,
  output logic [WORD_W-1:0] out_val,
  output logic              out_two,
  output logic              out_undef
);

  dec_rec_t          rec_one;
  dec_rec_t          rec_two;
  dec_rec_t          rec_q;
  logic              need_second;
  logic              awaiting_second;
  logic [WORD_W-1:0] held_first;
  logic              vld_q;

  // named events for the checker
  logic in_fire;
  logic out_fire;
  logic take_first;
  logic take_second;

  assign in_ready    = !vld_q || out_ready;
  assign in_fire     = in_valid && in_ready;
  assign out_fire    = vld_q && out_ready;
  assign take_first  = in_fire && !awaiting_second;
  assign take_second = in_fire && awaiting_second;

  w12_first_dec u_first (
    .word        (in_word),
    .rec         (rec_one),
    .need_second (need_second)
  );

  w12_second_merge u_merge (
    .first  (held_first),
    .second (in_word),
    .rec    (rec_two)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q           <= 1'b0;
      awaiting_second <= 1'b0;
      held_first      <= '0;
      rec_q           <= '0;
    end else begin
      if (out_fire) vld_q <= 1'b0;
      if (take_first && need_second) begin
        awaiting_second <= 1'b1;
        held_first      <= in_word;
      end
      if (take_first && !need_second) begin
        rec_q <= rec_one;
        vld_q <= 1'b1;
      end
      if (take_second) begin
        rec_q           <= rec_two;
        vld_q           <= 1'b1;
        awaiting_second <= 1'b0;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_op     = rec_q.op;
  assign out_rsel   = rec_q.rsel;
  assign out_fld_en = rec_q.fld_en;
  assign out_fld    = rec_q.fld;
  assign out_ind    = rec_q.ind;
  assign out_neg    = rec_q.neg;
  assign out_val    = rec_q.val;
  assign out_two    = rec_q.two;
  assign out_undef  = rec_q.undef;

endmodule

// File: rtl/w12_decoder_chk.sv
module w12_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [11:0] in_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [4:0]  out_op,
  input logic [1:0]  out_rsel,
  input logic        out_fld_en,
  input logic [1:0]  out_fld,
  input logic        out_ind,
  input logic        out_neg,
  input logic [11:0] out_val,
  input logic        out_two,
  input logic        out_undef,
  input logic        awaiting_second,
  input logic        take_first,
  input logic        take_second
);

  a_r1_stop_one_word: assert property (@(posedge clk) disable iff (rst)
    (take_first && in_word[11:6] == 6'd0) |=> (out_valid && out_op == 5'd0 && !out_two));

  a_r2_two_word_waits: assert property (@(posedge clk) disable iff (rst)
    (take_first && in_word[11:6] != 6'd0 && in_word[11:9] == 3'd0) |=> (awaiting_second && !out_valid));

  a_r4_undef_code: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_undef) |-> (out_op == 5'd31 && out_two));

  a_r9_stall_silent: assert property (@(posedge clk) disable iff (rst)
    (awaiting_second && !in_valid) |=> (awaiting_second && !out_valid));

  a_r10_hold_record: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rsel) &&
      $stable(out_fld_en) && $stable(out_fld) && $stable(out_ind) && $stable(out_neg) &&
      $stable(out_val) && $stable(out_two) && $stable(out_undef)));

  a_r10_no_take: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r12_next_cycle: assert property (@(posedge clk) disable iff (rst)
    take_second |=> (out_valid && out_two));

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      a_r11_reset_flush: assert (!awaiting_second && !out_valid);
    end
  end

endmodule

bind w12_decoder w12_decoder_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_word         (in_word),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_op          (out_op),
  .out_rsel        (out_rsel),
  .out_fld_en      (out_fld_en),
  .out_fld         (out_fld),
  .out_ind         (out_ind),
  .out_neg         (out_neg),
  .out_val         (out_val),
  .out_two         (out_two),
  .out_undef       (out_undef),
  .awaiting_second (awaiting_second),
  .take_first      (take_first),
  .take_second     (take_second)
);

// File: tb/w12_decoder_test.sv
module w12_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_word = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [4:0]  out_op;
  logic [1:0]  out_rsel;
  logic        out_fld_en;
  logic [1:0]  out_fld;
  logic        out_ind;
  logic        out_neg;
  logic [11:0] out_val;
  logic        out_two;
  logic        out_undef;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  w12_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_rsel(out_rsel),
    .out_fld_en(out_fld_en), .out_fld(out_fld), .out_ind(out_ind), .out_neg(out_neg),
    .out_val(out_val), .out_two(out_two), .out_undef(out_undef)
  );

  // record layout: op, rsel, fld_en, fld, ind, neg, val, two, undef
  function automatic logic [25:0] got_rec();
    return {out_op, out_rsel, out_fld_en, out_fld, out_ind, out_neg, out_val, out_two, out_undef};
  endfunction

  function automatic logic io_ok(input logic [11:0] b);
    case (b)
      12'o0101, 12'o0102, 12'o0104, 12'o0110,
      12'o0121, 12'o0122, 12'o0124, 12'o0130,
      12'o0141, 12'o0142, 12'o0144, 12'o0151, 12'o0152, 12'o0154: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic needs2(input logic [11:0] a);
    return (a >= 12'o0100) && (a < 12'o1000);
  endfunction

  function automatic logic [25:0] model(input logic [11:0] a, input logic [11:0] b);
    logic [4:0] op; logic [1:0] rs; logic fe; logic [1:0] fl;
    logic ind, neg, two, und; logic [11:0] v;
    op = 0; rs = 0; fe = 0; fl = 0; ind = 0; neg = 0; v = 0; two = 0; und = 0;
    if (a < 12'o0100) begin
      op = 0;
    end else if (a < 12'o1000) begin
      two = 1; v = b;
      if (a == 12'o0740) begin
        if (io_ok(b)) op = 10; else begin op = 31; und = 1; end
      end else if (a >= 12'o0240 && a < 12'o0700) begin
        op  = 5'((a - 12'o0240) / 32) + 5'd1;
        fe  = a[2]; fl = a[1:0]; ind = a[4];
        if (op == 1 || op == 4 || op == 5 || op == 6 || op == 7) rs = a[3] ? 2'd2 : 2'd1;
      end else begin
        op = 31; und = 1;
      end
    end else if (a < 12'o1400) begin
      op = 25; rs = a[7:6]; v = {6'd0, a[5:0]};
    end else if (a < 12'o2000) begin
      op = 26; rs = a[7:6]; v = {6'd0, a[5:0]};
    end else if (a < 12'o2400) begin
      op = 5'd11 + 5'(a[7:6]); v = {6'd0, a[5:0]};
    end else if (a < 12'o7400) begin
      op = 5'd15 + 5'((a - 12'o2400) / 256); v = {6'd0, a[5:0]}; neg = a[6]; ind = a[7];
    end else begin
      op = 27; v = {4'd0, a[7:0]};
    end
    return {op, rs, fe, fl, ind, neg, v, two, und};
  endfunction

  function automatic string tag_of(input logic [11:0] a, input logic [11:0] b);
    if (a < 12'o0100) return "R1";
    if (a == 12'o0740) return "R5";
    if (a < 12'o1000) return model(a, b)[0] ? "R4" : "R2/R3";
    if (a < 12'o2000) return "R8";
    if (a < 12'o2400) return "R6";
    if (a < 12'o7400) return "R7";
    return "R8";
  endfunction

  task automatic check(input logic ok, input string tag, input logic [25:0] act, input logic [25:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // stream storage
  logic [11:0] wq [0:1023];
  logic [11:0] fq [0:511];
  logic [11:0] sq [0:511];
  int nw = 0;
  int ne = 0;

  task automatic add_instr(input logic [11:0] a, input logic [11:0] b);
    wq[nw] = a; nw++;
    if (needs2(a)) begin wq[nw] = b; nw++; end
    fq[ne] = a; sq[ne] = needs2(a) ? b : 12'd0; ne++;
  endtask

  task automatic run_stream(input int gap, input int bp);
    int wi = 0;
    int ei = 0;
    int guard = 0;
    while (ei < ne && guard < 40000) begin
      @(negedge clk);
      in_valid  = (wi < nw) && (($urandom % 100) >= gap);
      in_word   = (wi < nw) ? wq[wi] : 12'($urandom);
      out_ready = (($urandom % 100) >= bp);
      #2;
      if (in_valid && in_ready) wi++;
      if (out_valid && out_ready) begin
        check(got_rec() == model(fq[ei], sq[ei]), tag_of(fq[ei], sq[ei]), got_rec(), model(fq[ei], sq[ei]));
        ei++;
      end
      guard++;
    end
    check(ei == ne, "R12 stream drained", 26'(ei), 26'(ne));
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    nw = 0; ne = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [25:0] snap;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    // R11 reset state
    check(!out_valid && in_ready, "R11 reset state", {24'd0, out_valid, in_ready}, 26'd1);

    // directed stream corners
    add_instr(12'o0000, 0); add_instr(12'o0077, 0); add_instr(12'o0040, 0);
    add_instr(12'o0100, 12'o1234); add_instr(12'o0237, 12'o7777);
    add_instr(12'o0240, 12'o0001); add_instr(12'o0257, 12'o4321); add_instr(12'o0277, 12'o0777);
    add_instr(12'o0350, 12'o0055); add_instr(12'o0640, 12'o2222); add_instr(12'o0617, 12'o3333);
    add_instr(12'o0700, 12'o0100); add_instr(12'o0777, 12'o0101);
    add_instr(12'o0740, 12'o0101); add_instr(12'o0740, 12'o0154); add_instr(12'o0740, 12'o0077);
    add_instr(12'o0740, 12'o0103); add_instr(12'o0740, 12'o0200); add_instr(12'o0740, 12'o0100);
    add_instr(12'o2077, 0); add_instr(12'o2177, 0); add_instr(12'o2277, 0); add_instr(12'o2377, 0);
    add_instr(12'o2400, 0); add_instr(12'o2577, 0); add_instr(12'o2677, 0); add_instr(12'o7377, 0);
    add_instr(12'o1000, 0); add_instr(12'o1377, 0); add_instr(12'o1500, 0); add_instr(12'o1777, 0);
    add_instr(12'o7400, 0); add_instr(12'o7777, 0);
    run_stream(0, 0);

    // random streams
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 200; i++) begin
        logic [11:0] a;
        logic [11:0] b;
        int sel;
        sel = $urandom % 8;
        a = 12'($urandom);
        b = 12'($urandom);
        if (sel == 0) a = a & 12'o0077;
        else if (sel <= 2) a = a & 12'o0777;
        else if (sel == 3) begin a = 12'o0740; b = 12'o0060 + 12'($urandom % 96); end
        add_instr(a, b);
      end
      run_stream(pass == 0 ? 20 : 50, pass == 0 ? 20 : 60);
    end

    // R12 latency and same-edge replacement; R10 back-pressure
    @(negedge clk);
    in_valid = 1; in_word = 12'o2345; out_ready = 0;
    #2; check(in_ready, "R12 ready while empty", {25'd0, in_ready}, 26'd1);
    @(negedge clk);
    in_word = 12'o1234;
    #2; check(out_valid && got_rec() == model(12'o2345, 0), "R12 one-cycle latency", got_rec(), model(12'o2345, 0));
    snap = got_rec();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      check(out_valid && !in_ready && got_rec() == snap, "R10 hold under stall", got_rec(), snap);
    end
    @(negedge clk);
    out_ready = 1;
    #2; check(in_ready, "R12 ready when draining", {25'd0, in_ready}, 26'd1);
    @(negedge clk);
    in_valid = 0;
    #2; check(out_valid && got_rec() == model(12'o1234, 0), "R12 same-edge replace", got_rec(), model(12'o1234, 0));
    @(negedge clk);

    // R9 stall between words
    in_valid = 1; in_word = 12'o0312; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    for (int k = 0; k < 4; k++) begin
      #2; check(!out_valid, "R9 silent while waiting", {25'd0, out_valid}, 26'd0);
      @(negedge clk);
    end
    in_valid = 1; in_word = 12'o1234;
    @(negedge clk);
    in_valid = 0;
    #2; check(out_valid && got_rec() == model(12'o0312, 12'o1234), "R9 merged after stall", got_rec(), model(12'o0312, 12'o1234));
    @(negedge clk);

    // R11 reset discards half instruction
    in_valid = 1; in_word = 12'o0452;
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    #2; check(!out_valid && in_ready, "R11 flushed", {24'd0, out_valid, in_ready}, 26'd1);
    @(negedge clk);
    in_valid = 1; in_word = 12'o2345;
    @(negedge clk);
    in_valid = 0;
    #2; check(out_valid && got_rec() == model(12'o2345, 0), "R11 fresh one-word after reset", got_rec(), model(12'o2345, 0));
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule